// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer that connects two unrelated clock domains. A producer writes 9-bit words on the write clock and a consumer reads them on the read clock. The default depth is 64 entries, and any power of two up to 4096 can be used. Each pointer is converted to Gray code before it crosses to the other domain. There it passes through a two-flop synchronizer, and the result is used to compute occupancy.

Four active-low status outputs report the FIFO state. Full and almost-full are registered on the write clock. Empty and almost-empty are registered on the read clock. Each almost flag compares occupancy against an offset register, and both offsets come out of reset at 7.

A shared control pin, `wr_aux`, is captured while reset is held, and its value selects one of two modes:
- **Dual-enable mode** (`wr_aux` high during reset): the pin acts as a second, active-high write enable.
- **Offset mode** (`wr_aux` low during reset): the pin acts as an active-low load select. When it is low, enabled writes and enabled reads go to the two offset registers instead of the data path.

A read needs both active-low read enables. The read data output floats when the output enable is high.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first write, both pointers sit at entry 0. Also in that state: `full_n`=1, `afull_n`=1, `empty_n`=0, `aempty_n`=0, and the read data register holds 0.
- R2: The value of `wr_aux` sampled while reset is held sets the mode. 1 selects dual-enable mode and 0 selects offset mode. The mode does not change until the next reset.
- R3: In dual-enable mode, a data write happens on a rising `wr_clk` edge only when `wr_en1_n`=0 and `wr_aux`=1. With `wr_aux`=0 nothing is written.
- R4: In offset mode, `wr_en1_n`=0 with `wr_aux`=1 writes data. `wr_en1_n`=0 with `wr_aux`=0 loads `wr_data` into an offset register, and no FIFO entry is written. Successive loads go almost-empty offset first, then almost-full offset, then wrap back to the first.
- R5: In offset mode, with `wr_aux`=0 and both read enables low, a read places an offset on `rd_data` in the same order as R4 (almost-empty, almost-full, wrap). This read does not move the read pointer and is allowed while empty.
- R6: A data read happens only when `rd_en1_n`=0 and `rd_en2_n`=0. `rd_data` changes at that read edge, and words come out in the order they were written.
- R7: A write attempted while `full_n`=0 is dropped. A full FIFO holds exactly DEPTH words.
- R8: A read attempted while `empty_n`=0 does not change `rd_data` or the read pointer.
- R9: `aempty_n` is 0 when occupancy is at or below the almost-empty offset. `afull_n` is 0 when occupancy is at or above DEPTH minus the almost-full offset. Both offsets default to 7 and are 9 bits wide.
- R10: When `out_en_n`=1, `rd_data` is high impedance.
- R11: A flag asserts at the clock edge of its own domain at which the local access makes it true. A flag cleared by the other domain clears within three edges of its own clock, and it never clears early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain through a synchronizer |
| wr_data | input | 9 | Write data word, or offset value when loading offsets |
| wr_en1_n | input | 1 | Active-low write enable |
| wr_aux | input | 1 | Mode pin at reset; afterwards a second write enable (dual mode) or active-low offset select (offset mode) |
| rd_en1_n | input | 1 | Active-low read enable, first of two |
| rd_en2_n | input | 1 | Active-low read enable, second of two |
| out_en_n | input | 1 | Active-low output enable for `rd_data` |
| rd_data | output | 9 | Registered read data, high impedance when disabled |
| full_n | output | 1 | Active-low full flag, write domain |
| afull_n | output | 1 | Active-low almost-full flag, write domain |
| empty_n | output | 1 | Active-low empty flag, read domain |
| aempty_n | output | 1 | Active-low almost-empty flag, read domain |

## Verification
A write changes `full_n` and `afull_n` at the same `wr_clk` edge, and a read changes `empty_n`, `aempty_n` and `rd_data` at the same `rd_clk` edge. The bench drives each access on a falling edge and samples these results on the next falling edge of the same clock. A change that crosses domains needs two synchronizer stages plus the flag register, so it lands within three edges of the receiving clock. The bench waits for these changes with a bounded poll and checks that the number of edges counted stays within that window. Threshold checks run only after the other domain has been idle long enough for its pointer to settle.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    MODE_OFFSET = 1'b0,
    MODE_DUAL   = 1'b1
  } dcf_mode_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_l,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side import dcf_pkg::*; #(
  parameter int DEPTH   = 64,
  parameter int WIDTH   = 9,
  parameter int DEF_OFS = 7,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             wr_clk,
  input  logic             rst_n,
  input  logic             wr_en1_n,
  input  logic             wr_aux,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [PW-1:0]    rgray_s,
  output logic             wr_rst_l,
  output logic [PW-1:0]    wgray,
  output logic [AW-1:0]    waddr,
  output logic             data_wr,
  output dcf_mode_e        mode,
  output logic [WIDTH-1:0] ae_ofs,
  output logic [WIDTH-1:0] af_ofs,
  output logic             full_n,
  output logic             afull_n
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic             rst_meta;
  logic [PW-1:0]    wbin, wbin_d, wgray_d, rbin_s, wcnt_d;
  logic             ofs_wr, wsel, wsel_d;
  logic             full_n_d, afull_n_d;
  logic [WIDTH-1:0] ae_ofs_d, af_ofs_d;

  // reset release aligned to wr_clk
  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) {rst_meta, wr_rst_l} <= 2'b00;
    else        {rst_meta, wr_rst_l} <= {1'b1, rst_meta};
  end

  // mode capture: loads only while the local reset is held
  always_ff @(posedge wr_clk) begin
    if (!wr_rst_l) mode <= dcf_mode_e'(wr_aux);
  end

  always_comb begin
    data_wr   = !wr_en1_n && wr_aux && full_n;
    ofs_wr    = !wr_en1_n && (mode == MODE_OFFSET) && !wr_aux;
    wbin_d    = wbin + {{(PW-1){1'b0}}, data_wr};
    wgray_d   = to_gray(wbin_d);
    rbin_s    = from_gray(rgray_s);
    wcnt_d    = wbin_d - rbin_s;
    full_n_d  = (int'(wcnt_d) != DEPTH);
    afull_n_d = (int'(wcnt_d) < DEPTH - int'(af_ofs));
    ae_ofs_d  = ae_ofs;
    af_ofs_d  = af_ofs;
    wsel_d    = wsel;
    if (ofs_wr) begin
      if (wsel) af_ofs_d = wr_data;
      else      ae_ofs_d = wr_data;
      wsel_d = !wsel;
    end
  end

  always_ff @(posedge wr_clk or negedge wr_rst_l) begin
    if (!wr_rst_l) begin
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
      ae_ofs  <= WIDTH'(DEF_OFS);
      af_ofs  <= WIDTH'(DEF_OFS);
      wsel    <= 1'b0;
    end else begin
      wbin    <= wbin_d;
      wgray   <= wgray_d;
      full_n  <= full_n_d;
      afull_n <= afull_n_d;
      ae_ofs  <= ae_ofs_d;
      af_ofs  <= af_ofs_d;
      wsel    <= wsel_d;
    end
  end

  assign waddr = wbin[AW-1:0];

  assert_no_write_when_full_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_l)
    !full_n |=> $stable(wbin));
  assert_full_implies_afull_R9: assert property (@(posedge wr_clk) disable iff (!wr_rst_l)
    !full_n |-> !afull_n);
  assert_wgray_single_step_R11: assert property (@(posedge wr_clk) disable iff (!wr_rst_l)
    $countones(wgray ^ $past(wgray)) <= 1);
  assert_mode_held_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_l)
    $past(wr_rst_l) |-> $stable(mode));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side import dcf_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             rd_en1_n,
  input  logic             rd_en2_n,
  input  logic             ld,
  input  dcf_mode_e        mode,
  input  logic [WIDTH-1:0] ae_ofs,
  input  logic [WIDTH-1:0] af_ofs,
  input  logic [PW-1:0]    wgray_s,
  input  logic [WIDTH-1:0] mem_rdata,
  output logic             rd_rst_l,
  output logic [PW-1:0]    rgray,
  output logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rd_q,
  output logic             empty_n,
  output logic             aempty_n
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic             rst_meta;
  logic             rd_req, ofs_rd, data_rd, rsel, rsel_d;
  logic [PW-1:0]    rbin, rbin_d, rgray_d, wbin_s, rcnt_d;
  logic             empty_n_d, aempty_n_d;
  logic [WIDTH-1:0] rd_q_d;

  // reset release aligned to rd_clk
  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) {rst_meta, rd_rst_l} <= 2'b00;
    else        {rst_meta, rd_rst_l} <= {1'b1, rst_meta};
  end

  always_comb begin
    rd_req     = !rd_en1_n && !rd_en2_n;
    ofs_rd     = rd_req && (mode == MODE_OFFSET) && !ld;
    data_rd    = rd_req && !ofs_rd && empty_n;
    rbin_d     = rbin + {{(PW-1){1'b0}}, data_rd};
    rgray_d    = to_gray(rbin_d);
    wbin_s     = from_gray(wgray_s);
    rcnt_d     = wbin_s - rbin_d;
    empty_n_d  = (rcnt_d != '0);
    aempty_n_d = (int'(rcnt_d) > int'(ae_ofs));
    rsel_d     = ofs_rd ? !rsel : rsel;
    if (ofs_rd)       rd_q_d = rsel ? af_ofs : ae_ofs;
    else if (data_rd) rd_q_d = mem_rdata;
    else              rd_q_d = rd_q;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_l) begin
    if (!rd_rst_l) begin
      rbin     <= '0;
      rgray    <= '0;
      rd_q     <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
      rsel     <= 1'b0;
    end else begin
      rbin     <= rbin_d;
      rgray    <= rgray_d;
      rd_q     <= rd_q_d;
      empty_n  <= empty_n_d;
      aempty_n <= aempty_n_d;
      rsel     <= rsel_d;
    end
  end

  assign raddr = rbin[AW-1:0];

  assert_no_read_when_empty_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_l)
    !empty_n |=> ($stable(rbin) && $stable(rd_q)) || $past(ofs_rd));
  assert_empty_implies_aempty_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_l)
    !empty_n |-> !aempty_n);
  assert_rgray_single_step_R11: assert property (@(posedge rd_clk) disable iff (!rd_rst_l)
    $countones(rgray ^ $past(rgray)) <= 1);
  assert_offset_read_keeps_ptr_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_l)
    ofs_rd |=> $stable(rbin));
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag import dcf_pkg::*; #(
  parameter int DEPTH   = 64,
  parameter int WIDTH   = 9,
  parameter int DEF_OFS = 7
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_en1_n,
  input  logic             wr_aux,
  input  logic             rd_en1_n,
  input  logic             rd_en2_n,
  input  logic             out_en_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             full_n,
  output logic             afull_n,
  output logic             empty_n,
  output logic             aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic             wr_rst_l, rd_rst_l, data_wr;
  logic [PW-1:0]    wgray, wgray_s, rgray, rgray_s;
  logic [AW-1:0]    waddr, raddr;
  logic [WIDTH-1:0] ae_ofs, af_ofs, mem_rdata, rd_q;
  dcf_mode_e        mode;

  dcf_wr_side #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DEF_OFS(DEF_OFS)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n), .wr_aux(wr_aux),
    .wr_data(wr_data), .rgray_s(rgray_s), .wr_rst_l(wr_rst_l), .wgray(wgray),
    .waddr(waddr), .data_wr(data_wr), .mode(mode), .ae_ofs(ae_ofs),
    .af_ofs(af_ofs), .full_n(full_n), .afull_n(afull_n)
  );

  dcf_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_l(wr_rst_l), .d(rgray), .q(rgray_s));
  dcf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_l(rd_rst_l), .d(wgray), .q(wgray_s));

  dcf_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .wr_clk(wr_clk), .we(data_wr), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  dcf_rd_side #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .ld(wr_aux), .mode(mode), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .wgray_s(wgray_s), .mem_rdata(mem_rdata), .rd_rst_l(rd_rst_l),
    .rgray(rgray), .raddr(raddr), .rd_q(rd_q), .empty_n(empty_n),
    .aempty_n(aempty_n)
  );

  assign rd_data = out_en_n ? 'z : rd_q;
endmodule

// File: tb/sim_dcfifo_pflag.sv
`timescale 1ns/100ps
module sim_dcfifo_pflag;
  localparam int DEPTH = 64;

  logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic [8:0] wr_data = '0;
  logic       wr_en1_n = 1'b1, wr_aux = 1'b1;
  logic       rd_en1_n = 1'b1, rd_en2_n = 1'b1, out_en_n = 1'b0;
  logic [8:0] rd_data;
  logic       full_n, afull_n, empty_n, aempty_n;

  int compared = 0, mismatched = 0;
  logic [8:0] sb[$];

  always #2.0 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  dcfifo_pflag #(.DEPTH(DEPTH)) u0 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_en1_n(wr_en1_n), .wr_aux(wr_aux), .rd_en1_n(rd_en1_n),
    .rd_en2_n(rd_en2_n), .out_en_n(out_en_n), .rd_data(rd_data),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic aux);
    @(negedge wr_clk);
    rst_n = 1'b0; wr_aux = aux; wr_en1_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (6) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    sb.delete();
  endtask

  task automatic wr_cyc(input logic e1n, input logic aux, input logic [8:0] d);
    @(negedge wr_clk);
    wr_en1_n = e1n; wr_aux = aux; wr_data = d;
    @(negedge wr_clk);
    wr_en1_n = 1'b1;
  endtask

  // driver: queues the word only if the design will accept it
  task automatic push(input logic [8:0] d);
    @(negedge wr_clk);
    if (full_n) sb.push_back(d);
    wr_en1_n = 1'b0; wr_aux = 1'b1; wr_data = d;
    @(negedge wr_clk);
    wr_en1_n = 1'b1;
  endtask

  task automatic rd_pulse(input logic r1, input logic r2);
    @(negedge rd_clk);
    rd_en1_n = r1; rd_en2_n = r2;
    @(negedge rd_clk);
    rd_en1_n = 1'b1; rd_en2_n = 1'b1;
  endtask

  // monitor: waits for data, reads once and compares against the queue head
  task automatic pop_chk(input string tag);
    logic [8:0] exp;
    int n;
    n = 0;
    @(negedge rd_clk);
    while (!empty_n && n < 20) begin
      @(negedge rd_clk);
      n++;
    end
    rd_en1_n = 1'b0; rd_en2_n = 1'b0;
    @(negedge rd_clk);
    rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    if (sb.size() == 0) begin
      exp = 9'h0;
      chk({tag, " queue underflow"}, 32'd1, 32'd0);
    end else begin
      exp = sb.pop_front();
    end
    chk(tag, {23'd0, rd_data}, {23'd0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [8:0] last;
    int n;
    // ---------- dual-enable mode ----------
    do_reset(1'b1);
    chk("R1 full_n", {31'd0, full_n}, 32'd1);
    chk("R1 afull_n", {31'd0, afull_n}, 32'd1);
    chk("R1 empty_n", {31'd0, empty_n}, 32'd0);
    chk("R1 aempty_n", {31'd0, aempty_n}, 32'd0);
    chk("R1 rd_data", {23'd0, rd_data}, 32'd0);

    out_en_n = 1'b1; #1;
    compared++;
    if (rd_data !== 9'bz) begin
      mismatched++;
      $display("FAIL R10: actual %b expected zzzzzzzzz", rd_data);
    end
    out_en_n = 1'b0;

    wr_cyc(1'b0, 1'b0, 9'h055);      // second enable low: no write
    wr_cyc(1'b1, 1'b1, 9'h066);      // first enable high: no write
    repeat (10) @(negedge rd_clk);
    chk("R3 R2 no write in dual mode", {31'd0, empty_n}, 32'd0);

    push(9'd5);
    n = 0;
    while (!empty_n && n < 10) begin
      @(negedge rd_clk);
      n++;
    end
    chk("R11 empty_n lag", {31'd0, (n >= 1 && n <= 4)}, 32'd1);

    for (int k = 2; k <= DEPTH; k++) begin
      push(9'((k * 37 + 5) & 511));
      if (k == 56) chk("R9 afull_n at 56", {31'd0, afull_n}, 32'd1);
      if (k == 57) chk("R9 afull_n at 57", {31'd0, afull_n}, 32'd0);
      if (k == 63) chk("R7 full_n at 63", {31'd0, full_n}, 32'd1);
      if (k == 64) chk("R7 full_n at 64", {31'd0, full_n}, 32'd0);
    end
    push(9'h1FF);                     // dropped: FIFO is full
    chk("R7 still full", {31'd0, full_n}, 32'd0);

    rd_pulse(1'b0, 1'b1);
    chk("R6 one enable only", {23'd0, rd_data}, 32'd0);
    rd_pulse(1'b1, 1'b0);
    chk("R6 other enable only", {23'd0, rd_data}, 32'd0);

    for (int k = DEPTH - 1; k >= 0; k--) begin
      pop_chk("R6 R7 order");
      if (k == 8) chk("R9 aempty_n at 8", {31'd0, aempty_n}, 32'd1);
      if (k == 7) chk("R9 aempty_n at 7", {31'd0, aempty_n}, 32'd0);
    end
    chk("R8 empty after drain", {31'd0, empty_n}, 32'd0);
    last = rd_data;
    rd_pulse(1'b0, 1'b0);
    chk("R8 read on empty", {23'd0, rd_data}, {23'd0, last});
    repeat (10) @(negedge wr_clk);
    chk("R11 full_n cleared", {31'd0, full_n}, 32'd1);
    chk("R11 afull_n cleared", {31'd0, afull_n}, 32'd1);

    // ---------- offset mode ----------
    do_reset(1'b0);
    wr_cyc(1'b0, 1'b0, 9'd3);         // almost-empty offset
    wr_cyc(1'b0, 1'b0, 9'd10);        // almost-full offset
    repeat (10) @(negedge rd_clk);
    chk("R4 offset load writes no data", {31'd0, empty_n}, 32'd0);
    rd_pulse(1'b0, 1'b0);
    chk("R5 R2 first offset", {23'd0, rd_data}, 32'd3);
    rd_pulse(1'b0, 1'b0);
    chk("R5 second offset", {23'd0, rd_data}, 32'd10);
    rd_pulse(1'b0, 1'b0);
    chk("R5 wrap", {23'd0, rd_data}, 32'd3);
    chk("R5 still empty", {31'd0, empty_n}, 32'd0);

    for (int i = 0; i < 4; i++) push(9'(9'h100 + i));
    repeat (10) @(negedge rd_clk);
    chk("R9 aempty_n at 4 with offset 3", {31'd0, aempty_n}, 32'd1);
    pop_chk("R4 data in offset mode");
    chk("R9 aempty_n at 3 with offset 3", {31'd0, aempty_n}, 32'd0);
    for (int i = 0; i < 3; i++) pop_chk("R4 data in offset mode");

    repeat (6) @(negedge wr_clk);
    for (int k = 1; k <= 54; k++) begin
      push(9'((k * 11 + 1) & 511));
      if (k == 53) chk("R9 afull_n at 53 offset 10", {31'd0, afull_n}, 32'd1);
      if (k == 54) chk("R9 afull_n at 54 offset 10", {31'd0, afull_n}, 32'd0);
    end
    for (int k = 0; k < 54; k++) pop_chk("R6 order offset mode");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule